// File: doc/BRIEF.md
# Switch-Addressed Parallel I/O Port Decoder

This block is a slave on an 8-bit I/O bus with a 16-bit port address. It claims one window of eight consecutive port addresses. A 6-bit switch input sets where that window sits, anywhere from 0x200 to 0x3F8 in steps of eight. The power-up switch value 6'h10 places it at 0x280.

The lower four offsets of the window reach four byte-wide ports, and each offset behaves differently for reads and writes. A write loads an output latch. A read returns input pins that have passed through a synchroniser.
- Offset 0 reaches isolated channels 7..0.
- Offset 1 reaches isolated channels 15..8.
- Offset 2 reaches general-purpose channels 7..0.
- Offset 3 reaches general-purpose channels 15..8.

The upper four offsets belong to an attached timer. The block raises a select for them and passes on a 2-bit sub-address, which picks counter 0, counter 1, counter 2, or the control byte at sub-address 3.

The bus is modelled synchronously. `bus_rd` and `bus_wr` are strobes sampled on the rising clock edge, with address and write data valid alongside them. The bus gives no back-pressure: every decoded cycle completes in the cycle it is presented. The shared data line is represented by `bus_rdata` together with the drive enable `bus_rdata_oe`. An enclosing pad ring turns this pair into a tri-state driver.

Top module: `iobus_port_decoder`

## Requirements
- R1: A cycle is decoded only when all of these hold: address bits 15..10 are 0, bit 9 is 1, bit (3+i) equals `sw_base[i]` for i = 0..5, and `bus_aen` is 0. An address outside the window changes no latch, does not raise `tmr_cs` and does not raise `bus_rdata_oe`.
- R2: A decoded write at offset 0, 1, 2 or 3 loads `bus_wdata` on that clock edge into `iso_out[7:0]`, `iso_out[15:8]`, `gp_out[7:0]` or `gp_out[15:8]` respectively. Data bit 0 maps to the lowest channel of that byte.
- R3: A decoded read at offset 0, 1, 2 or 3 presents the synchronised `iso_in[7:0]`, `iso_in[15:8]`, `gp_in[7:0]` or `gp_in[15:8]` respectively on `bus_rdata` in the same cycle.
- R4: Input pins pass through two flops. A value present before edge k is returned by reads after edge k+1, and a read after edge k alone still returns the previous value.
- R5: A decoded read or write at offsets 4..7 raises `tmr_cs` combinationally, with `tmr_sub` equal to address bits 1..0. Such a cycle changes no output latch and leaves `bus_rdata_oe` at 0.
- R6: While `bus_aen` is 1, a cycle is ignored: no latch changes, `tmr_cs` stays 0 and `bus_rdata_oe` stays 0.
- R7: Reset (`rst_n` low) clears all 32 output latches to 0.
- R8: `bus_rdata_oe` is 1 only during a decoded read at offsets 0..3. At every other time it is 0 and `bus_rdata` reads 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 16 | Port address |
| bus_aen | input | 1 | DMA address-enable; 1 blocks decoding |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| sw_base | input | 6 | Window position switches, bit i compares address bit 3+i |
| bus_rdata | output | 8 | Read data, 0 when not driving |
| bus_rdata_oe | output | 1 | Drive enable for the data bus |
| tmr_cs | output | 1 | Timer chip select |
| tmr_sub | output | 2 | Timer register sub-address |
| iso_in | input | 16 | Isolated input pins |
| gp_in | input | 16 | General-purpose input pins |
| iso_out | output | 16 | Isolated output latches |
| gp_out | output | 16 | General-purpose output latches |

## Verification
The hardest case to reach is the synchroniser boundary. It can only be observed when an input changes and a read lands exactly one edge later, before the second flop has caught up. The bench therefore changes a pin on a falling edge and reads once after a single rising edge, expecting the old value. It reads again after the next rising edge, expecting the new value. A second hard case is a write that misses the window by exactly one address condition. The bench covers this with addresses that differ from a hit in only bit 9, bit 10 or bit 3. It also moves the switches to both ends of the legal range.

// File: rtl/iopd_pkg.sv
package iopd_pkg;
  localparam int ADDR_W  = 16;
  localparam int SW_W    = 6;
  localparam int WIN_LG2 = 3;
  localparam int BYTE_W  = 8;
  localparam int GROUP_W = 16;
  localparam int NPORT   = (2 * GROUP_W) / BYTE_W;

  typedef enum logic [1:0] {
    PORT_ISO_LO = 2'd0,
    PORT_ISO_HI = 2'd1,
    PORT_GP_LO  = 2'd2,
    PORT_GP_HI  = 2'd3
  } port_sel_e;
endpackage

// File: rtl/iopd_window_match.sv
module iopd_window_match #(
  parameter int ADDR_W  = 16,
  parameter int SW_W    = 6,
  parameter int WIN_LG2 = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [SW_W-1:0]    sw,
  input  logic               aen,
  output logic               hit,
  output logic [WIN_LG2-1:0] offset
);
  localparam int TOP_BIT = WIN_LG2 + SW_W;
  localparam int HI_W    = ADDR_W - TOP_BIT - 1;

  logic base_eq;
  logic upper_ok;

  always_comb begin
    base_eq  = (addr[TOP_BIT-1:WIN_LG2] == sw);
    upper_ok = addr[TOP_BIT] && (addr[ADDR_W-1:TOP_BIT+1] == {HI_W{1'b0}});
    hit      = base_eq && upper_ok && !aen;
    offset   = addr[WIN_LG2-1:0];
  end
endmodule

// File: rtl/iopd_out_bank.sv
module iopd_out_bank #(
  parameter int NPORT  = 4,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [NPORT*BYTE_W-1:0] q
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[p*BYTE_W +: BYTE_W] <= '0;
      end else if (we && (idx == IDX_W'(p))) begin
        q[p*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/iopd_in_sync.sv
module iopd_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/iobus_port_decoder.sv
module iobus_port_decoder
  import iopd_pkg::*;
#(
  parameter int P_ADDR_W  = ADDR_W,
  parameter int P_SW_W    = SW_W,
  parameter int P_GROUP_W = GROUP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [P_ADDR_W-1:0]   bus_addr,
  input  logic                  bus_aen,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  input  logic [BYTE_W-1:0]     bus_wdata,
  input  logic [P_SW_W-1:0]     sw_base,
  output logic [BYTE_W-1:0]     bus_rdata,
  output logic                  bus_rdata_oe,
  output logic                  tmr_cs,
  output logic [WIN_LG2-2:0]    tmr_sub,
  input  logic [P_GROUP_W-1:0]  iso_in,
  input  logic [P_GROUP_W-1:0]  gp_in,
  output logic [P_GROUP_W-1:0]  iso_out,
  output logic [P_GROUP_W-1:0]  gp_out
);
  localparam int L_NPORT = (2 * P_GROUP_W) / BYTE_W;
  localparam int IDX_W   = WIN_LG2 - 1;
  localparam int ALL_W   = 2 * P_GROUP_W;

  logic               hit;
  logic [WIN_LG2-1:0] offset;
  logic               port_half;
  logic               tmr_half;
  logic [IDX_W-1:0]   port_idx;
  logic               port_we;
  logic [ALL_W-1:0]   latch_q;
  logic [ALL_W-1:0]   pins_raw;
  logic [ALL_W-1:0]   pins_sync;

  iopd_window_match #(
    .ADDR_W (P_ADDR_W),
    .SW_W   (P_SW_W),
    .WIN_LG2(WIN_LG2)
  ) match_i (
    .addr  (bus_addr),
    .sw    (sw_base),
    .aen   (bus_aen),
    .hit   (hit),
    .offset(offset)
  );

  always_comb begin
    port_half = hit && !offset[WIN_LG2-1];
    tmr_half  = hit &&  offset[WIN_LG2-1];
    port_idx  = offset[IDX_W-1:0];
    port_we   = port_half && bus_wr;
  end

  iopd_out_bank #(
    .NPORT (L_NPORT),
    .BYTE_W(BYTE_W),
    .IDX_W (IDX_W)
  ) bank_i (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (port_we),
    .idx  (port_idx),
    .wdata(bus_wdata),
    .q    (latch_q)
  );

  assign iso_out  = latch_q[P_GROUP_W-1:0];
  assign gp_out   = latch_q[ALL_W-1:P_GROUP_W];
  assign pins_raw = {gp_in, iso_in};

  iopd_in_sync #(
    .W     (ALL_W),
    .STAGES(2)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pins_raw),
    .q    (pins_sync)
  );

  always_comb begin
    bus_rdata_oe = port_half && bus_rd;
    bus_rdata    = '0;
    if (bus_rdata_oe) bus_rdata = pins_sync[port_idx*BYTE_W +: BYTE_W];
    tmr_cs  = tmr_half && (bus_rd || bus_wr);
    tmr_sub = offset[IDX_W-1:0];
  end
endmodule

// File: rtl/iopd_checker.sv
module iopd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] bus_addr,
  input logic        bus_aen,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [7:0]  bus_wdata,
  input logic [5:0]  sw_base,
  input logic        bus_rdata_oe,
  input logic        tmr_cs,
  input logic [15:0] iso_out,
  input logic [15:0] gp_out
);
  logic in_win;
  assign in_win = (bus_addr[15:10] == 6'd0) && bus_addr[9] &&
                  (bus_addr[8:3] == sw_base) && !bus_aen;

  p_oe_needs_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> (bus_rd && in_win && !bus_addr[2]));

  p_aen_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_aen |-> (!bus_rdata_oe && !tmr_cs));

  p_timer_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_cs |-> (!bus_rdata_oe && bus_addr[2]));

  p_latch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && in_win && !bus_addr[2]) |=> $stable({gp_out, iso_out}));

  p_iso_lo_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && in_win && bus_addr[2:0] == 3'd0) |=> (iso_out[7:0] == $past(bus_wdata)));

  p_gp_hi_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && in_win && bus_addr[2:0] == 3'd3) |=> (gp_out[15:8] == $past(bus_wdata)));

  p_reset_clear_r7: assert property (@(posedge clk)
    $rose(rst_n) |-> (iso_out == 16'd0 && gp_out == 16'd0));
endmodule

bind iobus_port_decoder iopd_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_aen     (bus_aen),
  .bus_rd      (bus_rd),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .sw_base     (sw_base),
  .bus_rdata_oe(bus_rdata_oe),
  .tmr_cs      (tmr_cs),
  .iso_out     (iso_out),
  .gp_out      (gp_out)
);

// File: tb/iobus_port_decoder_tb_top.sv
module iobus_port_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_aen = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [5:0]  sw_base = 6'h10;
  logic [7:0]  bus_rdata;
  logic        bus_rdata_oe;
  logic        tmr_cs;
  logic [1:0]  tmr_sub;
  logic [15:0] iso_in = '0;
  logic [15:0] gp_in = '0;
  logic [15:0] iso_out;
  logic [15:0] gp_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  iobus_port_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_aen(bus_aen),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .sw_base(sw_base),
    .bus_rdata(bus_rdata), .bus_rdata_oe(bus_rdata_oe), .tmr_cs(tmr_cs),
    .tmr_sub(tmr_sub), .iso_in(iso_in), .gp_in(gp_in),
    .iso_out(iso_out), .gp_out(gp_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic aen);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_aen = aen; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_aen = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, input logic aen,
                          output logic [7:0] d, output logic oe);
    @(negedge clk);
    bus_addr = a; bus_aen = aen; bus_rd = 1'b1;
    #1;
    d = bus_rdata; oe = bus_rdata_oe;
    bus_rd = 1'b0; bus_aen = 1'b0;
  endtask

  task automatic t_reset();
    chk("R7 iso_out after reset", 32'(iso_out), 32'h0);
    chk("R7 gp_out after reset", 32'(gp_out), 32'h0);
    chk("R8 idle oe", 32'(bus_rdata_oe), 32'h0);
    chk("R8 idle rdata", 32'(bus_rdata), 32'h0);
  endtask

  task automatic t_write_ports();
    bus_write(16'h0280, 8'hA5, 1'b0);
    bus_write(16'h0281, 8'h3C, 1'b0);
    bus_write(16'h0282, 8'h0F, 1'b0);
    bus_write(16'h0283, 8'h81, 1'b0);
    chk("R2 iso_out", 32'(iso_out), 32'h3CA5);
    chk("R2 gp_out", 32'(gp_out), 32'h810F);
  endtask

  task automatic t_read_ports();
    logic [7:0] d; logic oe;
    iso_in = 16'hBEEF; gp_in = 16'h1234;
    repeat (3) @(negedge clk);
    bus_read(16'h0280, 1'b0, d, oe); chk("R3 iso lo", 32'(d), 32'hEF); chk("R8 oe on read", 32'(oe), 32'h1);
    bus_read(16'h0281, 1'b0, d, oe); chk("R3 iso hi", 32'(d), 32'hBE);
    bus_read(16'h0282, 1'b0, d, oe); chk("R3 gp lo", 32'(d), 32'h34);
    bus_read(16'h0283, 1'b0, d, oe); chk("R3 gp hi", 32'(d), 32'h12);
    chk("R3 read leaves latches", 32'({gp_out, iso_out}), 32'h810F3CA5);
  endtask

  task automatic t_sync_latency();
    logic [7:0] d; logic oe;
    @(negedge clk);
    gp_in = 16'h12C3;
    @(posedge clk);
    #1;
    bus_addr = 16'h0282; bus_rd = 1'b1;
    @(negedge clk); #1;
    chk("R4 one edge old", 32'(bus_rdata), 32'h34);
    @(posedge clk);
    @(negedge clk); #1;
    chk("R4 two edges new", 32'(bus_rdata), 32'hC3);
    bus_rd = 1'b0;
    bus_read(16'h0282, 1'b0, d, oe);
    chk("R4 settled", 32'(d), 32'hC3);
  endtask

  task automatic t_timer();
    @(negedge clk);
    bus_addr = 16'h0287; bus_wdata = 8'h55; bus_wr = 1'b1; #1;
    chk("R5 cs on write", 32'(tmr_cs), 32'h1);
    chk("R5 sub on write", 32'(tmr_sub), 32'h3);
    @(negedge clk);
    bus_wr = 1'b0; #1;
    chk("R5 cs drops", 32'(tmr_cs), 32'h0);
    chk("R5 latches untouched", 32'({gp_out, iso_out}), 32'h810F3CA5);
    bus_addr = 16'h0285; bus_rd = 1'b1; #1;
    chk("R5 cs on read", 32'(tmr_cs), 32'h1);
    chk("R5 sub on read", 32'(tmr_sub), 32'h1);
    chk("R5 no drive", 32'(bus_rdata_oe), 32'h0);
    bus_addr = 16'h0280; #1;
    chk("R5 no cs at port offset", 32'(tmr_cs), 32'h0);
    bus_rd = 1'b0;
  endtask

  task automatic t_aen();
    logic [7:0] d; logic oe;
    bus_write(16'h0280, 8'h00, 1'b1);
    chk("R6 aen write ignored", 32'(iso_out), 32'h3CA5);
    bus_read(16'h0281, 1'b1, d, oe);
    chk("R6 aen read no oe", 32'(oe), 32'h0);
    @(negedge clk);
    bus_addr = 16'h0286; bus_aen = 1'b1; bus_rd = 1'b1; #1;
    chk("R6 aen no cs", 32'(tmr_cs), 32'h0);
    bus_rd = 1'b0; bus_aen = 1'b0;
  endtask

  task automatic t_window();
    logic [7:0] d; logic oe;
    bus_write(16'h0080, 8'hFF, 1'b0);
    bus_write(16'h0680, 8'hFF, 1'b0);
    bus_write(16'h0288, 8'hFF, 1'b0);
    chk("R1 misses ignored", 32'({gp_out, iso_out}), 32'h810F3CA5);
    bus_read(16'h0680, 1'b0, d, oe);
    chk("R1 miss read no oe", 32'(oe), 32'h0);
    sw_base = 6'h3F;
    bus_write(16'h03F9, 8'h77, 1'b0);
    chk("R1 top window write", 32'(iso_out), 32'h77A5);
    bus_write(16'h0281, 8'h00, 1'b0);
    chk("R1 old window dead", 32'(iso_out), 32'h77A5);
    sw_base = 6'h00;
    bus_write(16'h0202, 8'h11, 1'b0);
    chk("R1 bottom window write", 32'(gp_out), 32'h8111);
    sw_base = 6'h10;
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R7 reset clears", 32'({gp_out, iso_out}), 32'h0);
    rst_n = 1'b1;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_ports();
    t_read_ports();
    t_sync_latency();
    t_timer();
    t_aen();
    t_window();
    t_reset_again();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule